// File: doc/BRIEF.md
# Burst Address Generator

This block supplies the address that one port of a synchronous memory uses in every clock cycle. The caller presents an external address together with three active-low controls: a clear, an address strobe and a count enable. From these controls the block picks one of four actions. It can force the address to zero, take the external address, repeat the previous address, or step to the next address. The chosen address appears on the output in the same cycle, with no added latency. The block stores it on the rising edge, so a later burst continues from it.

The controls have a fixed priority: clear first, then strobe, then count enable. A clear may therefore coincide with a read or write of location zero without an idle cycle. Counting wraps from the last location of the configured depth back to zero. The chip-select state of the port has no bearing on the counter. A two-bit mode output reports which action was taken in the current cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the stored address to 0, whatever the other controls are doing. The first cycle after reset with all controls inactive outputs address 0 with mode 2 (hold).
- R2: While `clr_n` is low, `int_addr` is 0 and `mode_o` is 0 (reset) in the same cycle, regardless of `strobe_n` and `cnt_en_n`. The next cycle continues from 0.
- R3: While `clr_n` is high and `strobe_n` is low, `int_addr` equals `ext_addr` in the same cycle and `mode_o` is 1 (load).
- R4: While `clr_n` and `strobe_n` are high and `cnt_en_n` is low, `int_addr` is the previous cycle's `int_addr` plus one and `mode_o` is 3 (increment). After a load of A, the first increment gives A+1.
- R5: While all three controls are high, `int_addr` repeats the previous cycle's value, any value on `ext_addr` is ignored, and `mode_o` is 2 (hold).
- R6: Incrementing from address DEPTH-1 yields address 0.
- R7: When `strobe_n` and `cnt_en_n` are both low with `clr_n` high, the load wins: `int_addr` equals `ext_addr` and no step is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | AW | External address |
| strobe_n | input | 1 | Active-low address strobe (load) |
| cnt_en_n | input | 1 | Active-low count enable |
| clr_n | input | 1 | Active-low counter clear |
| int_addr | output | AW | Address used by the array this cycle |
| mode_o | output | 2 | Action taken: 0 reset, 1 load, 2 hold, 3 increment |

## Verification
The bench goes after priority collisions: a clear asserted together with strobe and count enable, and a strobe asserted together with count enable. A design with the priority inverted would output a stepped or external address where zero or the loaded value is due. Holds are driven while `ext_addr` changes, so a design that leaks the external address through would be exposed. Bursts run up to the top location so that a missing wrap shows up as a stale or out-of-range address. The cycle right after a load or a clear is checked for an off-by-one, as is the start-up state after a reset that coincided with a load.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   typedef enum logic [1:0] {
      MODE_RESET = 2'd0,
      MODE_LOAD  = 2'd1,
      MODE_HOLD  = 2'd2,
      MODE_INC   = 2'd3
   } addr_mode_t;
endpackage

// File: rtl/burst_addr_prio.sv
module burst_addr_prio
   import burst_addr_pkg::*;
(
   input  logic       strobe_n,
   input  logic       cnt_en_n,
   input  logic       clr_n,
   output addr_mode_t mode
);
   always_comb begin
      if (!clr_n)         mode = MODE_RESET;
      else if (!strobe_n) mode = MODE_LOAD;
      else if (!cnt_en_n) mode = MODE_INC;
      else                mode = MODE_HOLD;
   end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
   parameter int unsigned AW    = 15,
   parameter int unsigned DEPTH = 1 << AW
) (
   input  logic [AW-1:0] cur,
   output logic [AW-1:0] nxt
);
   localparam bit            FULL_SPAN = (DEPTH == (1 << AW));
   localparam logic [AW-1:0] LAST      = AW'(DEPTH - 1);

   generate
      if (FULL_SPAN) begin : g_natural
         assign nxt = cur + 1'b1;
      end else begin : g_bounded
         assign nxt = (cur >= LAST) ? '0 : cur + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int unsigned AW    = 15,
   parameter int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] ext_addr,
   input  logic          strobe_n,
   input  logic          cnt_en_n,
   input  logic          clr_n,
   output logic [AW-1:0] int_addr,
   output logic [1:0]    mode_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (AW < 1 || AW > 30) begin : g_bad_aw
         $error("burst_addr_gen: AW must lie in 1..30");
      end
      if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
         $error("burst_addr_gen: DEPTH must lie in 2..2**AW");
      end
   endgenerate

   addr_mode_t    mode;
   logic [AW-1:0] cnt_q;
   logic [AW-1:0] cnt_plus;

   burst_addr_prio u_prio (
      .strobe_n (strobe_n),
      .cnt_en_n (cnt_en_n),
      .clr_n    (clr_n),
      .mode     (mode)
   );

   burst_addr_step #(.AW(AW), .DEPTH(DEPTH)) u_step (
      .cur (cnt_q),
      .nxt (cnt_plus)
   );

   always_comb begin
      unique case (mode)
         MODE_RESET: int_addr = '0;
         MODE_LOAD:  int_addr = ext_addr;
         MODE_INC:   int_addr = cnt_plus;
         default:    int_addr = cnt_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= int_addr;
   end

   assign mode_o = mode;

   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
      !clr_n |-> (int_addr == '0 && mode_o == 2'd0)); // R2
   AST_LOAD_PASS: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !strobe_n) |-> (int_addr == ext_addr)); // R3
   AST_LOAD_OVER_COUNT: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !strobe_n && !cnt_en_n) |-> (mode_o == 2'd1)); // R7
   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && clr_n && strobe_n && cnt_en_n) |-> (int_addr == $past(int_addr))); // R5
   AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && clr_n && strobe_n && !cnt_en_n && $past(int_addr) != LAST)
      |-> (int_addr == AW'($past(int_addr) + 1'b1))); // R4
   AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && clr_n && strobe_n && !cnt_en_n && $past(int_addr) == LAST)
      |-> (int_addr == '0)); // R6
endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/1ps
module burst_addr_gen_bench;
   localparam int AW    = 15;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] ext_addr = '0;
   logic          strobe_n = 1'b1;
   logic          cnt_en_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [AW-1:0] int_addr;
   logic [1:0]    mode_o;

   int tests = 0;
   int fails = 0;
   int ref_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   burst_addr_gen #(.AW(AW), .DEPTH(DEPTH)) u_burst_addr_gen (
      .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
      .cnt_en_n(cnt_en_n), .clr_n(clr_n), .int_addr(int_addr), .mode_o(mode_o)
   );

   // One cycle: drive at negedge, check mid-low phase, update model at posedge.
   task automatic step(input int ext, input bit s, input bit e, input bit c,
                       input string req);
      int exp_a;
      int exp_m;
      @(negedge clk);
      ext_addr = AW'(ext);
      strobe_n = s;
      cnt_en_n = e;
      clr_n    = c;
      #2;
      if (!c)      begin exp_a = 0;                       exp_m = 0; end
      else if (!s) begin exp_a = ext % DEPTH;             exp_m = 1; end
      else if (!e) begin exp_a = (ref_cnt + 1) % DEPTH;   exp_m = 3; end
      else         begin exp_a = ref_cnt;                 exp_m = 2; end
      tests++;
      if (int_addr !== AW'(exp_a) || mode_o !== 2'(exp_m)) begin
         fails++;
         $display("FAIL %s: addr=%0h mode=%0d expected addr=%0h mode=%0d",
                  req, int_addr, mode_o, exp_a, exp_m);
      end
      @(posedge clk);
      ref_cnt = exp_a;
   endtask

   initial begin
      // R1: reset overrides a load presented at the same time
      @(negedge clk);
      ext_addr = 15'h1234; strobe_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0; strobe_n = 1'b1; ref_cnt = 0;
      step(16'h5555, 1, 1, 1, "R1");
      // R3 load, R4 increments after load
      step(16'h0100, 0, 1, 1, "R3");
      step(0, 1, 0, 1, "R4");
      step(0, 1, 0, 1, "R4");
      step(0, 1, 0, 1, "R4");
      // R5 hold while the external address moves
      step(16'h7abc, 1, 1, 1, "R5");
      step(16'h0001, 1, 1, 1, "R5");
      // R7 load beats count enable
      step(16'h0420, 0, 0, 1, "R7");
      step(0, 1, 1, 1, "R7");
      // R2 clear beats strobe and count enable, then count from 0
      step(16'h3333, 0, 0, 0, "R2");
      step(0, 1, 0, 1, "R2");
      step(0, 1, 1, 0, "R2");
      step(0, 1, 1, 1, "R2");
      // R6 wrap at the top
      step(DEPTH - 2, 0, 1, 1, "R6");
      step(0, 1, 0, 1, "R6");
      step(0, 1, 0, 1, "R6");
      step(0, 1, 0, 1, "R6");
      // mixed traffic; tag follows the expected action
      for (int i = 0; i < 400; i++) begin
         bit c = ($urandom % 8) != 0;
         bit s = ($urandom % 4) != 0;
         bit e = ($urandom % 2) != 0;
         int x = int'($urandom % DEPTH);
         string t;
         if (!c) t = "R2"; else if (!s) t = (!e ? "R7" : "R3");
         else if (!e) t = "R4"; else t = "R5";
         step(x, s, e, c, t);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule